// File: doc/BRIEF.md
# Multi-channel ADC scan sequencer

This block decides which of sixteen analog channels a successive-approximation conversion engine works on next, and in what order. It runs in one of three operating modes. Single mode converts one chosen channel once. Single-shot scan walks once from channel 0 up to a programmable last channel. Continuous scan repeats that walk until software stops it. An operation starts when software writes 1 to the start bit, or on a rising edge of one of four hardware event inputs, chosen by a select field.

For every channel the sequencer sends the engine a one-cycle start request with the channel number. It then waits for the engine's done pulse and stores the returned code in that channel's result register. Interrupt and DMA request pulses mark completions: every conversion in single mode, and every finished pass in the scan modes. In scan modes an optional settling aid holds the input discharge line for a fixed number of cycles before each channel is sampled. This keeps charge left from the previous channel out of the next sample.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, busy, conv_start, conv_disch, irq and dma_req are 0 and every result register reads 0.
- R2: With cfg_mode = 0 (single), a start converts channel cfg_chan exactly once, stores the code, raises irq and dma_req together for one cycle, and busy returns to 0.
- R3: With cfg_mode = 1 (single-shot scan; the value 3 acts the same), a start converts channels 0, 1, ... cfg_last once each in ascending order, and busy then returns to 0.
- R4: With cfg_mode = 2 (continuous scan), channel cfg_last is followed by channel 0 again. Writing the start bit with 0 (sw_start_wr = 1, sw_start_val = 0) ends the operation once the conversion in progress completes.
- R5: In the scan modes, irq and dma_req pulse together for one cycle only when the conversion of channel cfg_last completes, once per pass. Conversions of other channels produce no pulse, and a pulse always follows a conv_done cycle.
- R6: With cfg_hw_en = 1, a rising edge on hw_trig[cfg_trig_sel] starts an operation when idle. A level held high starts only one. Edges on the other trigger bits, or on any bit while cfg_hw_en = 0, have no effect.
- R7: A software start or a hardware edge that arrives while busy = 1 is ignored and does not change the channel sequence.
- R8: In the scan modes with cfg_disch_en = 1, conv_disch is high for exactly DISCH_CYC cycles directly before each conv_start pulse. conv_disch is never high in single mode or with cfg_disch_en = 0.
- R9: Each conv_done writes conv_data into the result register of the channel being converted, readable on rd_data when rd_chan selects it. No new conv_start is issued while a conversion is outstanding.
- R10: conv_chan stays unchanged from a conv_start pulse until the matching conv_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 single, 1 single-shot scan, 2 continuous scan, 3 as 1 |
| cfg_chan | input | 4 | Channel converted in single mode |
| cfg_last | input | 4 | Highest channel of a scan pass |
| cfg_hw_en | input | 1 | Enables hardware trigger starts |
| cfg_trig_sel | input | 2 | Selects which hw_trig bit starts operations |
| cfg_disch_en | input | 1 | Enables pre-sample discharge in scan modes |
| sw_start_wr | input | 1 | Write strobe for the start bit |
| sw_start_val | input | 1 | Value written to the start bit |
| hw_trig | input | 4 | Hardware trigger event inputs |
| busy | output | 1 | Start bit readback, 1 while an operation runs |
| conv_start | output | 1 | One-cycle start request to the conversion engine |
| conv_chan | output | 4 | Channel to convert |
| conv_disch | output | 1 | Input discharge request |
| conv_done | input | 1 | One-cycle completion pulse from the engine |
| conv_data | input | 10 | Conversion code, valid with conv_done |
| rd_chan | input | 4 | Result register read select |
| rd_data | output | 10 | Selected result register |
| irq | output | 1 | Interrupt request pulse |
| dma_req | output | 1 | DMA transfer request pulse |

## Verification
The checks assume the engine answers each conv_start with exactly one conv_done some cycles later and never sends a done on its own. They also assume the configuration inputs stay fixed while busy is high, since the discharge rule is judged against the current mode. The bench keeps to this with a responder that replies after a fixed latency to each request it sees. Every configuration change is made only after busy has fallen, and stop writes are issued only during a continuous scan.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int NUM_CH   = 16;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int RES_W    = 10;
    localparam int NUM_TRIG = 4;
    localparam int TS_W     = $clog2(NUM_TRIG);

    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'd0,
        MODE_ONESHOT = 2'd1,
        MODE_CONT    = 2'd2,
        MODE_ALT     = 2'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DISCH,
        ST_REQ,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic             vld;
        logic [CH_W-1:0]  ch;
        logic [RES_W-1:0] data;
    } res_wr_t;

    function automatic logic is_scan(input logic [1:0] m);
        return m != MODE_SINGLE;
    endfunction

    function automatic logic is_cont(input logic [1:0] m);
        return m == MODE_CONT;
    endfunction

endpackage

// File: rtl/adc_trig_unit.sv
module adc_trig_unit
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_en,
    input  logic [TS_W-1:0]     trig_sel,
    input  logic [NUM_TRIG-1:0] hw_trig,
    input  logic                sw_wr,
    input  logic                sw_val,
    output logic                start_req,
    output logic                stop_req
);
    logic [NUM_TRIG-1:0] trig_q;
    logic [NUM_TRIG-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= '0;
        else     trig_q <= hw_trig;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TRIG; gi++) begin : g_edge
            assign rise[gi] = hw_trig[gi] & ~trig_q[gi];
        end
    endgenerate

    assign start_req = (sw_wr & sw_val) | (hw_en & rise[trig_sel]);
    assign stop_req  = sw_wr & ~sw_val;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  res_wr_t          wr,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [RES_W-1:0] rd_data
);
    logic [RES_W-1:0] regs [NUM_CH];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[gi] <= '0;
                else if (wr.vld && wr.ch == CH_W'(gi))
                    regs[gi] <= wr.data;
            end
        end
    endgenerate

    assign rd_data = regs[rd_chan];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DISCH_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [CH_W-1:0]  single_ch,
    input  logic [CH_W-1:0]  last_ch,
    input  logic             disch_en,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             done,
    input  logic [RES_W-1:0] data,
    output logic             busy,
    output logic             req,
    output logic [CH_W-1:0]  ch,
    output logic             disch,
    output res_wr_t          wr,
    output logic             evt
);
    localparam int DC_W = (DISCH_CYC > 1) ? $clog2(DISCH_CYC) : 1;

    seq_state_e       st_q;
    logic [CH_W-1:0]  ch_q;
    logic [DC_W-1:0]  dcnt_q;
    logic             stop_q;
    logic             evt_q;
    logic             use_disch;
    logic             at_last;
    logic             halt;

    assign use_disch = is_scan(mode) && disch_en;
    assign at_last   = ch_q == last_ch;
    assign halt      = stop_q || stop_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ch_q   <= '0;
            dcnt_q <= '0;
            stop_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (st_q != ST_IDLE && stop_req) stop_q <= 1'b1;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_req) begin
                        ch_q   <= is_scan(mode) ? '0 : single_ch;
                        stop_q <= 1'b0;
                        dcnt_q <= '0;
                        st_q   <= use_disch ? ST_DISCH : ST_REQ;
                    end
                end
                ST_DISCH: begin
                    if (dcnt_q == DC_W'(DISCH_CYC - 1)) begin
                        dcnt_q <= '0;
                        st_q   <= ST_REQ;
                    end else begin
                        dcnt_q <= dcnt_q + 1'b1;
                    end
                end
                ST_REQ: st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (done) begin
                        if (!is_scan(mode)) begin
                            evt_q <= 1'b1;
                            st_q  <= ST_IDLE;
                        end else begin
                            evt_q <= at_last;
                            if (halt || (at_last && !is_cont(mode))) begin
                                st_q <= ST_IDLE;
                            end else begin
                                ch_q   <= at_last ? '0 : ch_q + 1'b1;
                                dcnt_q <= '0;
                                st_q   <= use_disch ? ST_DISCH : ST_REQ;
                            end
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = st_q != ST_IDLE;
    assign req     = st_q == ST_REQ;
    assign disch   = st_q == ST_DISCH;
    assign ch      = ch_q;
    assign evt     = evt_q;
    assign wr.vld  = (st_q == ST_WAIT) && done;
    assign wr.ch   = ch_q;
    assign wr.data = data;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int DISCH_CYC = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_mode,
    input  logic [CH_W-1:0]     cfg_chan,
    input  logic [CH_W-1:0]     cfg_last,
    input  logic                cfg_hw_en,
    input  logic [TS_W-1:0]     cfg_trig_sel,
    input  logic                cfg_disch_en,
    input  logic                sw_start_wr,
    input  logic                sw_start_val,
    input  logic [NUM_TRIG-1:0] hw_trig,
    output logic                busy,
    output logic                conv_start,
    output logic [CH_W-1:0]     conv_chan,
    output logic                conv_disch,
    input  logic                conv_done,
    input  logic [RES_W-1:0]    conv_data,
    input  logic [CH_W-1:0]     rd_chan,
    output logic [RES_W-1:0]    rd_data,
    output logic                irq,
    output logic                dma_req
);
    logic    start_req;
    logic    stop_req;
    logic    evt;
    res_wr_t res_wr;

    adc_trig_unit u_trig (
        .clk       (clk),
        .rst       (rst),
        .hw_en     (cfg_hw_en),
        .trig_sel  (cfg_trig_sel),
        .hw_trig   (hw_trig),
        .sw_wr     (sw_start_wr),
        .sw_val    (sw_start_val),
        .start_req (start_req),
        .stop_req  (stop_req)
    );

    adc_seq_ctrl #(.DISCH_CYC(DISCH_CYC)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_mode),
        .single_ch (cfg_chan),
        .last_ch   (cfg_last),
        .disch_en  (cfg_disch_en),
        .start_req (start_req),
        .stop_req  (stop_req),
        .done      (conv_done),
        .data      (conv_data),
        .busy      (busy),
        .req       (conv_start),
        .ch        (conv_chan),
        .disch     (conv_disch),
        .wr        (res_wr),
        .evt       (evt)
    );

    adc_result_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (res_wr),
        .rd_chan (rd_chan),
        .rd_data (rd_data)
    );

    assign irq     = evt;
    assign dma_req = evt;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
    import adc_seq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [1:0]      cfg_mode,
    input logic            cfg_disch_en,
    input logic            busy,
    input logic            conv_start,
    input logic [CH_W-1:0] conv_chan,
    input logic            conv_disch,
    input logic            conv_done,
    input logic            irq,
    input logic            dma_req
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst)             outstanding <= 1'b0;
        else if (conv_start) outstanding <= 1'b1;
        else if (conv_done)  outstanding <= 1'b0;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !irq && !dma_req));

    p_req_needs_busy_r1: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy);

    p_irq_after_done_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(conv_done));

    p_dma_after_done_r5: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> $past(conv_done));

    p_idle_after_done_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(conv_done));

    p_one_outstanding_r9: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !outstanding);

    p_chan_stable_r10: assert property (@(posedge clk) disable iff (rst)
        outstanding |-> $stable(conv_chan));

    p_disch_scan_only_r8: assert property (@(posedge clk) disable iff (rst)
        conv_disch |-> (cfg_mode != MODE_SINGLE && cfg_disch_en));

    p_no_disch_in_flight_r8: assert property (@(posedge clk) disable iff (rst)
        outstanding |-> !conv_disch);
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_mode     (cfg_mode),
    .cfg_disch_en (cfg_disch_en),
    .busy         (busy),
    .conv_start   (conv_start),
    .conv_chan    (conv_chan),
    .conv_disch   (conv_disch),
    .conv_done    (conv_done),
    .irq          (irq),
    .dma_req      (dma_req)
);

// File: tb/adc_scan_seq_bench.sv
`timescale 1ns/1ps
module adc_scan_seq_bench;
    localparam int DISCH = 3;
    localparam int LAT   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic [3:0] cfg_chan = 4'd0;
    logic [3:0] cfg_last = 4'd0;
    logic       cfg_hw_en = 1'b0;
    logic [1:0] cfg_trig_sel = 2'd0;
    logic       cfg_disch_en = 1'b0;
    logic       sw_start_wr = 1'b0;
    logic       sw_start_val = 1'b0;
    logic [3:0] hw_trig = 4'd0;
    logic       busy, conv_start, conv_disch, irq, dma_req;
    logic [3:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = 10'd0;
    logic [3:0] rd_chan = 4'd0;
    logic [9:0] rd_data;

    always #10 clk = ~clk;

    adc_scan_seq #(.DISCH_CYC(DISCH)) u_adc_scan_seq (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_chan(cfg_chan),
        .cfg_last(cfg_last), .cfg_hw_en(cfg_hw_en), .cfg_trig_sel(cfg_trig_sel),
        .cfg_disch_en(cfg_disch_en), .sw_start_wr(sw_start_wr),
        .sw_start_val(sw_start_val), .hw_trig(hw_trig), .busy(busy),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_disch(conv_disch),
        .conv_done(conv_done), .conv_data(conv_data), .rd_chan(rd_chan),
        .rd_data(rd_data), .irq(irq), .dma_req(dma_req)
    );

    int n_chk = 0;
    int n_fail = 0;
    int seed = 7;
    int nlog = 0;
    int log_ch [0:63];
    int log_dc [0:63];
    int irqs = 0;
    int dmas = 0;
    int mism = 0;
    int drun = 0;
    int lat_cnt = 0;
    int pend_ch = 0;
    bit finished = 0;

    function automatic logic [9:0] eng_val(int ch);
        return 10'((ch * 53 + seed) % 1024);
    endfunction

    // engine model and monitor, all on the falling edge
    always @(negedge clk) begin
        if (rst) begin
            conv_done <= 1'b0;
            lat_cnt = 0;
        end else begin
            conv_done <= 1'b0;
            if (conv_start) begin
                lat_cnt = LAT;
                pend_ch = int'(conv_chan);
                if (nlog < 64) begin
                    log_ch[nlog] = int'(conv_chan);
                    log_dc[nlog] = drun;
                end
                nlog++;
            end else if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    conv_done <= 1'b1;
                    conv_data <= eng_val(pend_ch);
                end
            end
            drun = conv_disch ? drun + 1 : 0;
            if (irq) irqs++;
            if (dma_req) dmas++;
            if (irq != dma_req) mism++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_log();
        @(posedge clk);
        nlog = 0; irqs = 0; dmas = 0; mism = 0;
    endtask

    task automatic sw_write(input logic v);
        @(negedge clk);
        sw_start_wr = 1'b1; sw_start_val = v;
        @(negedge clk);
        sw_start_wr = 1'b0; sw_start_val = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (3) @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chan = 4'd0; @(negedge clk);
        chk(rd_data == 10'd0, "R1 result ch0", int'(rd_data), 0);
        rd_chan = 4'd15; @(negedge clk);
        chk(rd_data == 10'd0, "R1 result ch15", int'(rd_data), 0);
        chk(!busy && !conv_start && !conv_disch, "R1 busy/start/disch",
            int'({busy, conv_start, conv_disch}), 0);
        chk(!irq && !dma_req, "R1 irq/dma", int'({irq, dma_req}), 0);
    endtask

    task automatic t_single();
        clr_log();
        seed = 11; cfg_mode = 2'd0; cfg_chan = 4'd9; cfg_disch_en = 1'b1;
        sw_write(1'b1);
        chk(busy == 1'b1, "R2 busy readback", int'(busy), 1);
        wait_idle();
        chk(nlog == 1, "R2 one conversion", nlog, 1);
        chk(log_ch[0] == 9, "R2 channel", log_ch[0], 9);
        chk(irqs == 1 && dmas == 1 && mism == 0, "R2 irq/dma pulses", irqs*10 + dmas, 11);
        chk(log_dc[0] == 0, "R8 no discharge in single", log_dc[0], 0);
        rd_chan = 4'd9; @(negedge clk);
        chk(rd_data == eng_val(9), "R9 single result", int'(rd_data), int'(eng_val(9)));
        rd_chan = 4'd8; @(negedge clk);
        chk(rd_data == 10'd0, "R9 other channel untouched", int'(rd_data), 0);
    endtask

    task automatic t_oneshot();
        clr_log();
        seed = 100; cfg_mode = 2'd1; cfg_last = 4'd5; cfg_disch_en = 1'b1;
        sw_write(1'b1);
        wait_idle();
        chk(nlog == 6, "R3 pass length", nlog, 6);
        for (int i = 0; i < 6; i++) begin
            chk(log_ch[i] == i, "R3 channel order", log_ch[i], i);
            chk(log_dc[i] == DISCH, "R8 discharge length", log_dc[i], DISCH);
        end
        chk(irqs == 1 && dmas == 1 && mism == 0, "R5 one pulse per pass", irqs, 1);
        for (int i = 0; i < 6; i++) begin
            rd_chan = 4'(i); @(negedge clk);
            chk(rd_data == eng_val(i), "R9 scan result", int'(rd_data), int'(eng_val(i)));
        end
    endtask

    task automatic t_oneshot_alt_nodisch();
        clr_log();
        seed = 3; cfg_mode = 2'd3; cfg_last = 4'd15; cfg_disch_en = 1'b0;
        sw_write(1'b1);
        wait_idle();
        chk(nlog == 16, "R3 full pass mode 3", nlog, 16);
        chk(log_ch[15] == 15 && log_ch[0] == 0, "R3 ends at last", log_ch[15], 15);
        chk(log_dc[7] == 0, "R8 discharge disabled", log_dc[7], 0);
        chk(irqs == 1, "R5 single pass irq", irqs, 1);
    endtask

    task automatic t_cont();
        clr_log();
        seed = 500; cfg_mode = 2'd2; cfg_last = 4'd2; cfg_disch_en = 1'b0;
        sw_write(1'b1);
        while (nlog < 7) @(negedge clk);
        chk(busy == 1'b1, "R4 still running", int'(busy), 1);
        sw_write(1'b0);
        wait_idle();
        chk(nlog >= 7 && nlog <= 8, "R4 stops after current", nlog, 7);
        for (int i = 0; i < 8; i++)
            if (i < nlog) chk(log_ch[i] == i % 3, "R4 wrap order", log_ch[i], i % 3);
        chk(irqs == nlog / 3 && mism == 0, "R5 pulses per completed pass", irqs, nlog / 3);
        idle_cycles(20);
        chk(busy == 1'b0 && nlog <= 8, "R4 stays stopped", int'(busy), 0);
    endtask

    task automatic t_hw();
        clr_log();
        seed = 20; cfg_mode = 2'd0; cfg_chan = 4'd4;
        cfg_hw_en = 1'b0; cfg_trig_sel = 2'd2;
        @(negedge clk) hw_trig = 4'b0100;
        idle_cycles(4);
        @(negedge clk) hw_trig = 4'b0000;
        idle_cycles(10);
        chk(nlog == 0 && !busy, "R6 disabled trigger ignored", nlog, 0);
        cfg_hw_en = 1'b1;
        @(negedge clk) hw_trig = 4'b1011;
        idle_cycles(4);
        @(negedge clk) hw_trig = 4'b0000;
        idle_cycles(10);
        chk(nlog == 0 && !busy, "R6 unselected inputs ignored", nlog, 0);
        @(negedge clk) hw_trig = 4'b0100;
        idle_cycles(40);
        chk(nlog == 1 && log_ch[0] == 4, "R6 selected edge starts once", nlog, 1);
        @(negedge clk) hw_trig = 4'b0000;
        wait_idle();
        rd_chan = 4'd4; @(negedge clk);
        chk(rd_data == eng_val(4), "R6 triggered result", int'(rd_data), int'(eng_val(4)));
    endtask

    task automatic t_busy_ignore();
        clr_log();
        seed = 77; cfg_mode = 2'd1; cfg_last = 4'd5; cfg_disch_en = 1'b1;
        cfg_hw_en = 1'b1; cfg_trig_sel = 2'd0;
        sw_write(1'b1);
        while (nlog < 2) @(negedge clk);
        sw_write(1'b1);
        @(negedge clk) hw_trig = 4'b0001;
        idle_cycles(2);
        @(negedge clk) hw_trig = 4'b0000;
        wait_idle();
        idle_cycles(10);
        chk(nlog == 6, "R7 sequence unchanged", nlog, 6);
        chk(log_ch[2] == 2 && log_ch[5] == 5, "R7 order kept", log_ch[2], 2);
        chk(irqs == 1 && !busy, "R7 single pass completion", irqs, 1);
        cfg_hw_en = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_oneshot();
        t_oneshot_alt_nodisch();
        t_cont();
        t_hw();
        t_busy_ignore();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule